// File: doc/BRIEF.md
# Pipelined Burst SRAM Cycle Controller

This block is a synchronous single-port memory with a burst-style front end. Every address, write datum, chip select, strobe, advance and write-enable input is captured on the rising clock edge. A cycle can start in two ways. A processor strobe always starts a read. A controller strobe starts a read or a write, depending on the write enables. Later cycles either advance or hold at the address that was loaded. The next address in a burst comes from a separate sequencer, so this block reuses the address it holds.

Read data passes through an output register. A separate drive-enable pipeline controls the tri-state data bus. When a deselect occurs, that pipeline keeps the bus driven for one extra cycle. The output enable gates the drivers combinationally. A snooze input also forces the bus off at once. After a delay, snooze stops the block from sampling its inputs, and the memory contents are kept.

Top module: `burst_sram_ctl`

## Requirements
- R1: While reset is asserted, and afterwards until a read cycle is registered, `dq_oe` is 0 and `dq_out` is 0.
- R2: A read cycle registered at edge N loads `dq_out` with the addressed word at edge N+1, and `dq_oe` is 1 from that edge while `oe_n` is 0.
- R3: A controller-strobe cycle with all three selects asserted (`sel_n`=0, `sel_hi`=1, `sel2_n`=0) is decoded as follows:
  - `allwr_n`=0 writes every lane.
  - Otherwise, `lanewr_n`=0 writes each lane k whose `lane_n[k]` is 0. Lane k is bits [k*LANE_W +: LANE_W], and its top bit is the parity bit.
  - With no write enabled, the cycle is a read.
- R4: A processor-strobe cycle is a read whatever the write enables are. If the next edge carries write enables with `adv_n`=1, that edge writes `dq_in` to the address just loaded.
- R5: A processor strobe presented while `sel_n`=1 has no effect. An ongoing access continues unchanged.
- R6: A controller strobe with `sel_n`=1, or any strobe with `sel_hi`=0 or `sel2_n`=1, deselects the block. Later advance cycles then do nothing until a new selected strobe arrives.
- R7: After a deselect registered at edge N that follows a read, `dq_oe` stays 1 after edge N+1 and is 0 after edge N+2.
- R8: `oe_n`=1 forces `dq_oe` to 0 without waiting for a clock edge, and `oe_n`=0 restores it.
- R9: After a write, `dq_oe` stays 0 through hold cycles until a new strobe or an advance read occurs.
- R10: When both strobes are low on one edge and the processor strobe is enabled (`sel_n`=0), the processor strobe wins and the cycle is a read.
- R11: `snooze`=1 forces `dq_oe` to 0 at once. An edge ignores all other inputs when `snooze` was sampled high two edges earlier. Memory contents survive the snooze.
- R12: With the block selected and no strobe active, `adv_n`=0 performs a read or a lane write at the held address.
- R13: Select inputs are sampled only on strobe cycles. Changing them during advance or hold cycles does not interrupt the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| snooze | input | 1 | Low-power request; drivers off immediately, inputs gated after two edges |
| addr | input | AW | External word address, loaded on strobe cycles |
| dq_in | input | LANES*LANE_W | Write data |
| dq_out | output | LANES*LANE_W | Registered read data |
| dq_oe | output | 1 | Data bus driver enable |
| oe_n | input | 1 | Asynchronous output enable, active low |
| pstrb_n | input | 1 | Processor address strobe, active low |
| cstrb_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Advance, active low; high holds |
| sel_n | input | 1 | Primary select, active low |
| sel_hi | input | 1 | Second select, active high |
| sel2_n | input | 1 | Third select, active low |
| allwr_n | input | 1 | Global write, active low |
| lanewr_n | input | 1 | Lane-write qualifier, active low |
| lane_n | input | LANES | Per-lane write enables, active low |

## Verification
Three pairs of events can fall on the same cycle, and the bench provokes each one:
- Both strobes low on one edge, with the global write also low. The bench checks that the old word is read back and that no write reaches the array.
- A processor-strobe read followed on the very next edge by a write to the loaded address. Here the output register shows the old data while the write is pending, and a later read returns the new word.
- Snooze raised while a hold-read is still in flight. The bench offers a write strobe once the gate is active, then checks after exit that the bus stayed off and the word is unchanged.

// File: rtl/sbc_pkg.sv
package sbc_pkg;
   typedef enum logic [1:0] {
      OP_IDLE  = 2'd0,
      OP_RD    = 2'd1,
      OP_WR    = 2'd2,
      OP_DESEL = 2'd3
   } sbc_op_e;
endpackage

// File: rtl/sbc_lane_decode.sv
module sbc_lane_decode #(
   parameter int LANES = 4
) (
   input  logic             allwr_n,
   input  logic             lanewr_n,
   input  logic [LANES-1:0] lane_n,
   output logic [LANES-1:0] mask,
   output logic             wr_req
);
   for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign mask[i] = ~allwr_n | (~lanewr_n & ~lane_n[i]);
   end
   assign wr_req = |mask;
endmodule

// File: rtl/sbc_snooze_gate.sv
module sbc_snooze_gate #(
   parameter int DLY = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic snooze,
   output logic gate
);
   logic [DLY-1:0] sr;

   if (DLY < 1) begin : g_bad
      $error("sbc_snooze_gate: DLY must be at least 1");
   end

   if (DLY == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
         if (!rst_n) sr <= '0;
         else        sr <= snooze;
   end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
         if (!rst_n) sr <= '0;
         else        sr <= {sr[DLY-2:0], snooze};
   end

   assign gate = sr[DLY-1];
endmodule

// File: rtl/sbc_cycle_decode.sv
module sbc_cycle_decode
   import sbc_pkg::*;
#(
   parameter int AW    = 4,
   parameter int LANES = 4,
   parameter int W     = 36
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             gate,
   input  logic             pstrb_n,
   input  logic             cstrb_n,
   input  logic             adv_n,
   input  logic             sel_n,
   input  logic             sel_hi,
   input  logic             sel2_n,
   input  logic [AW-1:0]    addr,
   input  logic [W-1:0]     dq_in,
   input  logic [LANES-1:0] mask,
   input  logic             wr_req,
   output sbc_op_e          op_q,
   output logic [AW-1:0]    addr_q,
   output logic [W-1:0]     wdata_q,
   output logic [LANES-1:0] wmask_q
);
   logic    active_q, wr_last_q;
   logic    active_d, wr_last_d;
   sbc_op_e op_d;
   logic [AW-1:0] addr_d;
   logic    p_go, c_go, sel_all;

   assign p_go    = ~pstrb_n & ~sel_n;
   assign c_go    = ~cstrb_n & ~p_go;
   assign sel_all = ~sel_n & sel_hi & ~sel2_n;

   always_comb begin
      op_d      = OP_IDLE;
      addr_d    = addr_q;
      active_d  = active_q;
      wr_last_d = wr_last_q;
      if (gate) begin
         op_d      = active_q ? OP_DESEL : OP_IDLE;
         active_d  = 1'b0;
         wr_last_d = 1'b0;
      end else if (p_go) begin
         addr_d = addr;
         if (sel_all) begin
            op_d      = OP_RD;
            active_d  = 1'b1;
            wr_last_d = 1'b0;
         end else begin
            op_d      = OP_DESEL;
            active_d  = 1'b0;
            wr_last_d = 1'b0;
         end
      end else if (c_go) begin
         addr_d = addr;
         if (sel_all) begin
            active_d  = 1'b1;
            op_d      = wr_req ? OP_WR : OP_RD;
            wr_last_d = wr_req;
         end else begin
            op_d      = OP_DESEL;
            active_d  = 1'b0;
            wr_last_d = 1'b0;
         end
      end else if (active_q) begin
         if (wr_req) begin
            op_d      = OP_WR;
            wr_last_d = 1'b1;
         end else if (!adv_n || !wr_last_q) begin
            op_d      = OP_RD;
            wr_last_d = 1'b0;
         end else begin
            op_d      = OP_IDLE;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_q      <= OP_IDLE;
         addr_q    <= '0;
         active_q  <= 1'b0;
         wr_last_q <= 1'b0;
         wdata_q   <= '0;
         wmask_q   <= '0;
      end else begin
         op_q      <= op_d;
         addr_q    <= addr_d;
         active_q  <= active_d;
         wr_last_q <= wr_last_d;
         wdata_q   <= dq_in;
         wmask_q   <= mask;
      end
   end
endmodule

// File: rtl/sbc_array_pipe.sv
module sbc_array_pipe
   import sbc_pkg::*;
#(
   parameter int DEPTH  = 16,
   parameter int LANES  = 4,
   parameter int LANE_W = 9,
   parameter int AW     = 4,
   parameter int W      = 36
) (
   input  logic             clk,
   input  logic             rst_n,
   input  sbc_op_e          op_q,
   input  logic [AW-1:0]    addr_q,
   input  logic [W-1:0]     wdata_q,
   input  logic [LANES-1:0] wmask_q,
   output logic [W-1:0]     dout,
   output logic             drv
);
   logic rd_prev;

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic [LANE_W-1:0] cells [DEPTH];
      logic [LANE_W-1:0] rd_q;

      always_ff @(posedge clk)
         if (op_q == OP_WR && wmask_q[i])
            cells[addr_q] <= wdata_q[i*LANE_W +: LANE_W];

      always_ff @(posedge clk or negedge rst_n)
         if (!rst_n)              rd_q <= '0;
         else if (op_q == OP_RD)  rd_q <= cells[addr_q];

      assign dout[i*LANE_W +: LANE_W] = rd_q;
   end

   // second enable stage: a deselect right after a read lingers one cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_prev <= 1'b0;
         drv     <= 1'b0;
      end else begin
         rd_prev <= (op_q == OP_RD);
         drv     <= (op_q == OP_RD) | ((op_q == OP_DESEL) & rd_prev);
      end
   end
endmodule

// File: rtl/burst_sram_ctl.sv
module burst_sram_ctl
   import sbc_pkg::*;
#(
   parameter int DEPTH   = 16,
   parameter int LANES   = 4,
   parameter int LANE_W  = 9,
   parameter int SNZ_DLY = 2,
   localparam int AW     = $clog2(DEPTH),
   localparam int W      = LANES * LANE_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             snooze,
   input  logic [AW-1:0]    addr,
   input  logic [W-1:0]     dq_in,
   output logic [W-1:0]     dq_out,
   output logic             dq_oe,
   input  logic             oe_n,
   input  logic             pstrb_n,
   input  logic             cstrb_n,
   input  logic             adv_n,
   input  logic             sel_n,
   input  logic             sel_hi,
   input  logic             sel2_n,
   input  logic             allwr_n,
   input  logic             lanewr_n,
   input  logic [LANES-1:0] lane_n
);
   if (!(LANES == 2 || LANES == 4)) begin : g_bad_lanes
      $error("burst_sram_ctl: LANES must be 2 or 4");
   end
   if (LANE_W < 2) begin : g_bad_lw
      $error("burst_sram_ctl: LANE_W must be at least 2");
   end
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("burst_sram_ctl: DEPTH must be a power of two");
   end

   logic             snz_gate;
   logic [LANES-1:0] lmask;
   logic             wr_req;
   sbc_op_e          op_q;
   logic [AW-1:0]    addr_q;
   logic [W-1:0]     wdata_q;
   logic [LANES-1:0] wmask_q;
   logic             drv;

   sbc_snooze_gate #(.DLY(SNZ_DLY)) u_snz (
      .clk(clk), .rst_n(rst_n), .snooze(snooze), .gate(snz_gate));

   sbc_lane_decode #(.LANES(LANES)) u_lane (
      .allwr_n(allwr_n), .lanewr_n(lanewr_n), .lane_n(lane_n),
      .mask(lmask), .wr_req(wr_req));

   sbc_cycle_decode #(.AW(AW), .LANES(LANES), .W(W)) u_dec (
      .clk(clk), .rst_n(rst_n), .gate(snz_gate),
      .pstrb_n(pstrb_n), .cstrb_n(cstrb_n), .adv_n(adv_n),
      .sel_n(sel_n), .sel_hi(sel_hi), .sel2_n(sel2_n),
      .addr(addr), .dq_in(dq_in), .mask(lmask), .wr_req(wr_req),
      .op_q(op_q), .addr_q(addr_q), .wdata_q(wdata_q), .wmask_q(wmask_q));

   sbc_array_pipe #(.DEPTH(DEPTH), .LANES(LANES), .LANE_W(LANE_W),
                    .AW(AW), .W(W)) u_arr (
      .clk(clk), .rst_n(rst_n), .op_q(op_q), .addr_q(addr_q),
      .wdata_q(wdata_q), .wmask_q(wmask_q), .dout(dq_out), .drv(drv));

   assign dq_oe = drv & ~oe_n & ~snooze;
endmodule

// File: rtl/burst_sram_ctl_chk.sv
module burst_sram_ctl_chk
   import sbc_pkg::*;
(
   input logic    clk,
   input logic    rst_n,
   input logic    gate,
   input logic    pstrb_n,
   input logic    cstrb_n,
   input logic    sel_n,
   input logic    sel_hi,
   input logic    sel2_n,
   input logic    allwr_n,
   input sbc_op_e op_q,
   input logic    drv,
   input logic    dq_oe
);
   // R9
   wr_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!gate && pstrb_n && !cstrb_n && !sel_n && sel_hi && !sel2_n && !allwr_n)
      |=> ##1 !dq_oe);

   // R2
   rd_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_q == OP_RD) |=> drv);

   // R7
   dcd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_q == OP_DESEL && $past(op_q) == OP_RD) |=> drv);

   // R7
   idle_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_q == OP_IDLE) |=> !drv);

   // R11
   snz_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      gate |=> (op_q == OP_IDLE || op_q == OP_DESEL));

   // R10
   pstrb_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!gate && !pstrb_n && !sel_n && sel_hi && !sel2_n) |=> (op_q == OP_RD));
endmodule

bind burst_sram_ctl burst_sram_ctl_chk u_chk (
   .clk(clk), .rst_n(rst_n), .gate(snz_gate),
   .pstrb_n(pstrb_n), .cstrb_n(cstrb_n),
   .sel_n(sel_n), .sel_hi(sel_hi), .sel2_n(sel2_n),
   .allwr_n(allwr_n), .op_q(op_q), .drv(drv), .dq_oe(dq_oe));

// File: tb/sim_burst_sram_ctl.sv
module sim_burst_sram_ctl;
   localparam int CLK_NS = 10;
   localparam int LANES  = 4;
   localparam int LANE_W = 9;
   localparam int DEPTH  = 16;
   localparam int AW     = 4;
   localparam int W      = 36;
   localparam int NVEC   = 8;

   logic clk = 1'b0;
   logic rst_n, snooze, oe_n, pstrb_n, cstrb_n, adv_n;
   logic sel_n, sel_hi, sel2_n, allwr_n, lanewr_n;
   logic [LANES-1:0] lane_n;
   logic [AW-1:0]    addr;
   logic [W-1:0]     dq_in, dq_out;
   logic             dq_oe;

   burst_sram_ctl #(.DEPTH(DEPTH), .LANES(LANES), .LANE_W(LANE_W)) u0 (
      .clk(clk), .rst_n(rst_n), .snooze(snooze), .addr(addr),
      .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe), .oe_n(oe_n),
      .pstrb_n(pstrb_n), .cstrb_n(cstrb_n), .adv_n(adv_n),
      .sel_n(sel_n), .sel_hi(sel_hi), .sel2_n(sel2_n),
      .allwr_n(allwr_n), .lanewr_n(lanewr_n), .lane_n(lane_n));

   always #(CLK_NS/2) clk = ~clk;

   int n_chk  = 0;
   int n_fail = 0;
   logic [W-1:0] bm [DEPTH];

   // {addr, global, lanes, data}
   localparam logic [44:0] VEC [NVEC] = '{
      {4'd3,  1'b1, 4'b0000, 36'h123456789},
      {4'd5,  1'b0, 4'b1111, 36'hABCDEF012},
      {4'd5,  1'b0, 4'b0010, 36'h000000000},
      {4'd3,  1'b0, 4'b1001, 36'hFFFFFFFFF},
      {4'd9,  1'b1, 4'b0000, 36'h155AA33CC},
      {4'd9,  1'b0, 4'b0000, 36'h000000000},
      {4'd15, 1'b1, 4'b0000, 36'h800000001},
      {4'd15, 1'b0, 4'b0100, 36'h777777777}
   };

   task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic idle_in();
      pstrb_n = 1'b1; cstrb_n = 1'b1; adv_n = 1'b1;
      sel_n = 1'b0; sel_hi = 1'b1; sel2_n = 1'b0;
      allwr_n = 1'b1; lanewr_n = 1'b1; lane_n = '1;
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic glob,
                     input logic [LANES-1:0] ln, input logic [W-1:0] d);
      cstrb_n = 1'b0; addr = a; dq_in = d;
      allwr_n = ~glob; lanewr_n = 1'b0; lane_n = ~ln;
      tick();
      idle_in();
      tick();
      for (int k = 0; k < LANES; k++)
         if (glob || ln[k]) bm[a][k*LANE_W +: LANE_W] = d[k*LANE_W +: LANE_W];
   endtask

   task automatic rd(input logic [AW-1:0] a, output logic [W-1:0] q, output logic oe);
      cstrb_n = 1'b0; addr = a;
      tick();
      idle_in();
      tick();
      q  = dq_out;
      oe = dq_oe;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      logic [W-1:0] q, old;
      logic         oe;
      idle_in();
      oe_n = 1'b0; snooze = 1'b0; addr = '0; dq_in = '0; rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk("R1 oe in reset", W'(dq_oe), '0);
      chk("R1 dout in reset", dq_out, '0);
      rst_n = 1'b1;
      tick();
      chk("R1 oe after reset", W'(dq_oe), '0);

      // table walk: lane writes and read-back (R2, R3)
      for (int v = 0; v < NVEC; v++) begin
         wr(VEC[v][44:41], VEC[v][40], VEC[v][39:36], VEC[v][35:0]);
         rd(VEC[v][44:41], q, oe);
         chk("R3 lane write data", q, bm[VEC[v][44:41]]);
         chk("R2 read drives bus", W'(oe), W'(1));
      end

      // R9: bus stays off after a write during hold cycles
      wr(4'd7, 1'b1, 4'b0000, 36'h0DEADBEEF);
      chk("R9 oe after write", W'(dq_oe), '0);
      tick();
      chk("R9 oe held off", W'(dq_oe), '0);

      // R4: processor strobe reads, then delayed write
      old = bm[7];
      pstrb_n = 1'b0; addr = 4'd7; allwr_n = 1'b0; dq_in = 36'h111111111;
      tick();
      pstrb_n = 1'b1; allwr_n = 1'b0; adv_n = 1'b1; dq_in = 36'h0ABCABCAB;
      tick();
      chk("R4 strobe read ignores writes", dq_out, old);
      chk("R4 read drives bus", W'(dq_oe), W'(1));
      idle_in();
      tick();
      bm[7] = 36'h0ABCABCAB;
      rd(4'd7, q, oe);
      chk("R4 delayed write landed", q, bm[7]);

      // R10: both strobes low, processor wins
      old = bm[3];
      pstrb_n = 1'b0; cstrb_n = 1'b0; addr = 4'd3; allwr_n = 1'b0; dq_in = 36'h0;
      tick();
      idle_in();
      tick();
      chk("R10 collision reads", dq_out, old);
      chk("R10 collision drives", W'(dq_oe), W'(1));
      rd(4'd3, q, oe);
      chk("R10 no write on collision", q, old);

      // R5: processor strobe with sel_n high is ignored
      rd(4'd5, q, oe);
      pstrb_n = 1'b0; sel_n = 1'b1; addr = 4'd9;
      tick();
      idle_in();
      tick();
      tick();
      chk("R5 access continues oe", W'(dq_oe), W'(1));
      chk("R5 access continues data", dq_out, bm[5]);

      // R7: double-cycle deselect
      rd(4'd3, q, oe);
      cstrb_n = 1'b0; sel_n = 1'b1;
      tick();
      idle_in();
      chk("R7 oe at deselect edge", W'(dq_oe), W'(1));
      tick();
      chk("R7 oe one edge later", W'(dq_oe), W'(1));
      tick();
      chk("R7 oe off two edges later", W'(dq_oe), '0);

      // R6: deselect via sel_hi, advance then does nothing
      rd(4'd5, q, oe);
      cstrb_n = 1'b0; sel_hi = 1'b0;
      tick();
      idle_in(); adv_n = 1'b0;
      tick();
      tick();
      adv_n = 1'b1;
      tick();
      chk("R6 deselected stays off", W'(dq_oe), '0);

      // R13: selects ignored during advance cycles
      rd(4'd9, q, oe);
      adv_n = 1'b0; sel_n = 1'b1; sel_hi = 1'b0; sel2_n = 1'b1;
      tick(); tick(); tick();
      chk("R13 oe kept", W'(dq_oe), W'(1));
      chk("R13 data kept", dq_out, bm[9]);
      idle_in();

      // R12: advance cycle writes one lane at the held address
      wr(4'd12, 1'b1, 4'b0000, 36'h123123123);
      adv_n = 1'b0; lanewr_n = 1'b0; lane_n = 4'b1110; dq_in = 36'h0FF0FF0FF;
      tick();
      idle_in();
      tick();
      bm[12][LANE_W-1:0] = 9'h0FF;
      rd(4'd12, q, oe);
      chk("R12 advance lane write", q, bm[12]);

      // R8: asynchronous output enable
      oe_n = 1'b1;
      #1;
      chk("R8 oe_n high turns off", W'(dq_oe), '0);
      oe_n = 1'b0;
      #1;
      chk("R8 oe_n low turns on", W'(dq_oe), W'(1));

      // R11: snooze gating and retention
      @(negedge clk);
      rd(4'd3, q, oe);
      snooze = 1'b1;
      #1;
      chk("R11 snooze forces off", W'(dq_oe), '0);
      tick();
      tick();
      cstrb_n = 1'b0; addr = 4'd3; allwr_n = 1'b0; dq_in = 36'h0;
      tick();
      tick();
      chk("R11 off during snooze", W'(dq_oe), '0);
      idle_in();
      snooze = 1'b0;
      tick(); tick(); tick();
      rd(4'd3, q, oe);
      chk("R11 contents retained", q, bm[3]);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule